// File: doc/BRIEF.md
# Breakpoint Acknowledge Cycle Sequencer

This block runs the bus cycle that acknowledges a hardware breakpoint. When a breakpoint request arrives while the block is idle, it puts a fixed signature on a 20-bit address bus. The signature sets the function code to the processor's special address space and marks the transfer as a word-sized read. One clock later it asserts the address and data strobes together. It then waits for the responder to answer with either a transfer acknowledge or a bus error.

Either answer ends the cycle. The block raises a one-clock exception-start pulse and records whether the answer was a bus error. It drops the strobes in the same cycle and then holds off until the responder withdraws its answer. Only after that does it return to idle and accept a new request.

Top module: `bkpt_ack_seq`

## Requirements
- R1: Out of reset and whenever idle, the strobes, `bus_drive_o`, `busy_o` and `exc_start_o` are low, and `addr_o`, `fc_o`, `size_o` and `rd_o` are all zero.
- R2: A request sampled at a clock edge while idle makes `busy_o` and `bus_drive_o` high after that edge, with the strobes still low. The signature is `addr_o` = 20'h0001E: bits [19:16] hold special-space type 0, bits [4:1] are ones, and bits [15:5] and bit 0 are zero. Alongside it, `fc_o` = 3'b111 (processor space), `size_o` = 2'b10 (word) and `rd_o` = 1 (read).
- R3: The address and data strobes rise together one clock after the signature appears, never while the signature is absent, and stay high until a response is sampled.
- R4: A response is sampled only from the second clock edge that sees the strobes high. A response present only at the first such edge is ignored.
- R5: After the edge that samples a response, `exc_start_o` is high for exactly one clock. `exc_berr_o` then equals the bus-error input at that edge, where a bus error wins over a simultaneous acknowledge. It keeps that value until the next request is accepted, which clears it.
- R6: In the cycle of the exception pulse the strobes are low while the signature is still driven.
- R7: After the strobes drop, the block spends at least one clock with `busy_o` high and `bus_drive_o` low. It stays there while the acknowledge or bus error is high, and returns to idle one clock after an edge that samples both low.
- R8: A request raised while the block is busy has no effect. After such a request is withdrawn and the cycle completes, no new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bkpt_req_i | input | 1 | Breakpoint request, level sensitive |
| xfer_ack_i | input | 1 | Responder transfer acknowledge (active high) |
| berr_i | input | 1 | Responder bus error (active high) |
| addr_o | output | 20 | Address bus |
| fc_o | output | 3 | Function code (address space) |
| size_o | output | 2 | Transfer size |
| rd_o | output | 1 | Direction, 1 = read |
| bus_drive_o | output | 1 | Address, function code, size and direction are valid |
| addr_strb_o | output | 1 | Address strobe |
| data_strb_o | output | 1 | Data strobe |
| exc_start_o | output | 1 | One-clock pulse: start exception processing |
| exc_berr_o | output | 1 | Last response was a bus error |
| busy_o | output | 1 | A cycle is in progress |

## Verification
The bench sweeps three things: the response delay from zero to four extra wait clocks, the response kind (acknowledge, bus error, or both at once), and how long the responder holds its answer after the strobes drop, from zero to two clocks. The delay separates correct sampling from early sampling. A spurious response is injected at the first strobe edge whenever the delay is non-zero, which catches a sequencer that samples too early. The response kind separates the bus-error priority and the flag capture. The hold length tells apart a sequencer that waits for withdrawal from one that returns to idle on a fixed count. Requests raised during the busy phase show that only the idle state accepts them.

// File: rtl/bkpt_ack_pkg.sv
package bkpt_ack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SETUP       = 3'd1,
        ST_STROBE      = 3'd2,
        ST_WAIT_RESP   = 3'd3,
        ST_RELEASE     = 3'd4,
        ST_WAIT_NEGATE = 3'd5
    } bk_state_e;

    typedef struct packed {
        bk_state_e state;
        logic      exc_start;
        logic      exc_berr;
    } bk_regs_t;

    localparam bk_regs_t BK_RESET = '{state: ST_IDLE, exc_start: 1'b0, exc_berr: 1'b0};

endpackage

// File: rtl/bkpt_sig_enc.sv
module bkpt_sig_enc #(
    parameter int                ADDR_W     = 20,
    parameter int                FC_W       = 3,
    parameter int                SIZE_W     = 2,
    parameter int                TYPE_W     = 4,
    parameter logic [TYPE_W-1:0] SPACE_TYPE = '0,
    parameter logic [FC_W-1:0]   FC_CPU     = '1,
    parameter logic [SIZE_W-1:0] SIZE_WORD  = 2'b10
) (
    input  logic              drive_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [FC_W-1:0]   fc_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              rd_o
);
    localparam int TYPE_LSB = ADDR_W - TYPE_W;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
        if (b >= TYPE_LSB) begin : g_type
            assign addr_o[b] = drive_i & SPACE_TYPE[b - TYPE_LSB];
        end else if (b >= 1 && b <= 4) begin : g_ones
            assign addr_o[b] = drive_i;
        end else begin : g_zero
            assign addr_o[b] = 1'b0;
        end
    end

    assign fc_o   = drive_i ? FC_CPU : '0;
    assign size_o = drive_i ? SIZE_WORD : '0;
    assign rd_o   = drive_i;

endmodule

// File: rtl/bkpt_resp_det.sv
module bkpt_resp_det (
    input  logic arm_i,
    input  logic xfer_ack_i,
    input  logic berr_i,
    output logic any_o,
    output logic hit_o,
    output logic berr_o
);
    assign any_o  = xfer_ack_i | berr_i;
    assign hit_o  = arm_i & any_o;
    assign berr_o = berr_i;
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq #(
    parameter int                ADDR_W     = 20,
    parameter int                FC_W       = 3,
    parameter int                SIZE_W     = 2,
    parameter int                TYPE_W     = 4,
    parameter logic [TYPE_W-1:0] SPACE_TYPE = '0,
    parameter logic [FC_W-1:0]   FC_CPU     = '1,
    parameter logic [SIZE_W-1:0] SIZE_WORD  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bkpt_req_i,
    input  logic              xfer_ack_i,
    input  logic              berr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [FC_W-1:0]   fc_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              rd_o,
    output logic              bus_drive_o,
    output logic              addr_strb_o,
    output logic              data_strb_o,
    output logic              exc_start_o,
    output logic              exc_berr_o,
    output logic              busy_o
);
    import bkpt_ack_pkg::*;

    bk_regs_t r_d, r_q;
    logic     resp_any, resp_hit, resp_berr;
    logic     drive, strobe;

    bkpt_resp_det u_resp (
        .arm_i      (r_q.state == ST_WAIT_RESP),
        .xfer_ack_i (xfer_ack_i),
        .berr_i     (berr_i),
        .any_o      (resp_any),
        .hit_o      (resp_hit),
        .berr_o     (resp_berr)
    );

    always_comb begin
        r_d           = r_q;
        r_d.exc_start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (bkpt_req_i) begin
                    r_d.state    = ST_SETUP;
                    r_d.exc_berr = 1'b0;
                end
            end
            ST_SETUP:  r_d.state = ST_STROBE;
            ST_STROBE: r_d.state = ST_WAIT_RESP;
            ST_WAIT_RESP: begin
                if (resp_hit) begin
                    r_d.state     = ST_RELEASE;
                    r_d.exc_start = 1'b1;
                    r_d.exc_berr  = resp_berr;
                end
            end
            ST_RELEASE: r_d.state = ST_WAIT_NEGATE;
            ST_WAIT_NEGATE: begin
                if (!resp_any) r_d.state = ST_IDLE;
            end
            default: r_d = BK_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= BK_RESET;
        else        r_q <= r_d;
    end

    assign drive  = (r_q.state == ST_SETUP) || (r_q.state == ST_STROBE) ||
                    (r_q.state == ST_WAIT_RESP) || (r_q.state == ST_RELEASE);
    assign strobe = (r_q.state == ST_STROBE) || (r_q.state == ST_WAIT_RESP);

    bkpt_sig_enc #(
        .ADDR_W     (ADDR_W),
        .FC_W       (FC_W),
        .SIZE_W     (SIZE_W),
        .TYPE_W     (TYPE_W),
        .SPACE_TYPE (SPACE_TYPE),
        .FC_CPU     (FC_CPU),
        .SIZE_WORD  (SIZE_WORD)
    ) u_sig (
        .drive_i (drive),
        .addr_o  (addr_o),
        .fc_o    (fc_o),
        .size_o  (size_o),
        .rd_o    (rd_o)
    );

    assign bus_drive_o = drive;
    assign addr_strb_o = strobe;
    assign data_strb_o = strobe;
    assign exc_start_o = r_q.exc_start;
    assign exc_berr_o  = r_q.exc_berr;
    assign busy_o      = (r_q.state != ST_IDLE);

endmodule

// File: rtl/bkpt_ack_seq_chk.sv
module bkpt_ack_seq_chk #(
    parameter int                ADDR_W     = 20,
    parameter int                TYPE_W     = 4,
    parameter logic [TYPE_W-1:0] SPACE_TYPE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_ack_i,
    input logic              berr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              rd_o,
    input logic              bus_drive_o,
    input logic              addr_strb_o,
    input logic              data_strb_o,
    input logic              exc_start_o,
    input logic              exc_berr_o,
    input logic              busy_o
);
    AST_SIG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> (addr_o[ADDR_W-1 -: TYPE_W] == SPACE_TYPE) &&
                        (addr_o[4:0] == 5'b11110) && rd_o) else $error("sig"); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_drive_o && !addr_strb_o && (addr_o == '0)) else $error("idle"); // R1
    AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strb_o == data_strb_o) else $error("pair"); // R3
    AST_STROBE_AFTER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strb_o |-> bus_drive_o && $past(bus_drive_o)) else $error("order"); // R3
    AST_EXC_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |-> $past(xfer_ack_i || berr_i) && $past(addr_strb_o)) else $error("resp"); // R4
    AST_EXC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |=> !exc_start_o) else $error("pulse"); // R5
    AST_BERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |-> exc_berr_o == $past(berr_i)) else $error("berr"); // R5
    AST_RELEASE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |-> !addr_strb_o && bus_drive_o) else $error("release"); // R6
    AST_IDLE_AFTER_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(!xfer_ack_i && !berr_i)) else $error("withdraw"); // R7
endmodule

bind bkpt_ack_seq bkpt_ack_seq_chk #(
    .ADDR_W     (ADDR_W),
    .TYPE_W     (TYPE_W),
    .SPACE_TYPE (SPACE_TYPE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_ack_i  (xfer_ack_i),
    .berr_i      (berr_i),
    .addr_o      (addr_o),
    .rd_o        (rd_o),
    .bus_drive_o (bus_drive_o),
    .addr_strb_o (addr_strb_o),
    .data_strb_o (data_strb_o),
    .exc_start_o (exc_start_o),
    .exc_berr_o  (exc_berr_o),
    .busy_o      (busy_o)
);

// File: tb/bkpt_ack_seq_bench.sv
module bkpt_ack_seq_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, ack = 1'b0, berr = 1'b0;
    logic [19:0] addr;
    logic [2:0]  fc;
    logic [1:0]  size;
    logic        rd, drv, as_s, ds_s, exc, exb, busy;

    int checks = 0;
    int errors = 0;

    localparam logic [19:0] EXP_ADDR = (20'd1 << 4) | (20'd1 << 3) | (20'd1 << 2) | (20'd1 << 1);

    always #(CLK_P/2) clk = ~clk;

    bkpt_ack_seq u_bkpt_ack_seq (
        .clk(clk), .rst_n(rst_n), .bkpt_req_i(req), .xfer_ack_i(ack), .berr_i(berr),
        .addr_o(addr), .fc_o(fc), .size_o(size), .rd_o(rd), .bus_drive_o(drv),
        .addr_strb_o(as_s), .data_strb_o(ds_s), .exc_start_o(exc), .exc_berr_o(exb),
        .busy_o(busy)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({busy, drv, as_s, ds_s, exc}, 5'b0, {tag, " R1 idle controls"});
        chk({addr, fc, size, rd}, 26'd0, {tag, " R1 idle bus zero"});
    endtask

    task automatic run(input int d, input int kind, input int h);
        logic exp_b;
        exp_b = (kind != 0);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk({busy, drv, as_s, ds_s}, 4'b1100, "R2 setup controls");
        chk(addr, EXP_ADDR, "R2 address signature");
        chk({fc, size, rd}, {3'b111, 2'b10, 1'b1}, "R2 fc size dir");
        chk(exb, 1'b0, "R5 flag cleared on accept");
        @(negedge clk);
        chk({as_s, ds_s, drv}, 3'b111, "R3 strobes rise");
        if (d > 0) begin ack = 1'b1; berr = 1'b1; end
        for (int k = 0; k <= d; k++) begin
            @(negedge clk);
            chk({as_s, exc}, 2'b10, "R4 no early response");
            req = (k < d);
            if (k < d) begin ack = 1'b0; berr = 1'b0; end
            else begin ack = (kind != 1); berr = (kind != 0); end
        end
        @(negedge clk); req = 1'b0;
        chk(exc, 1'b1, "R5 exception pulse");
        chk(exb, exp_b, "R5 bus error flag");
        chk({as_s, ds_s, drv}, 3'b001, "R6 strobes dropped, signature kept");
        for (int j = 0; j < h; j++) begin
            @(negedge clk);
            chk({busy, drv, as_s, exc}, 4'b1000, "R7 waiting for withdrawal");
        end
        ack = 1'b0; berr = 1'b0;
        if (h == 0) begin
            @(negedge clk);
            chk({busy, drv, exc}, 3'b100, "R7 minimum wait clock");
        end
        @(negedge clk);
        chk_idle("R7 back to idle");
        chk(exb, exp_b, "R5 flag held");
        @(negedge clk);
        chk(busy, 1'b0, "R8 request while busy ignored");
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 2 + 1);
        chk_idle("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        for (int d = 0; d <= 4; d++)
            for (int kind = 0; kind <= 2; kind++)
                for (int h = 0; h <= 2; h++)
                    run(d, kind, h);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule